// File: doc/BRIEF.md
# Minislot Dynamic Segment Arbiter

This block decides, once per communication cycle, which locally queued event-driven frames go out during the dynamic segment of a time-triggered bus. No bit-level contention takes place. Every node keeps a slot counter and counts minislots in the same way. A minislot in which nobody transmits passes as a short idle gap. A minislot in which a frame starts stretches until the bus goes quiet again. A local frame is released when the counter reaches that frame's ID. Priority therefore comes from time alone: lower IDs come up earlier. The segment is a fixed number of macroticks long, and anything not sent by then waits for the next cycle.

The host pulses the segment start together with a bitmap of pending frame IDs, and the block captures that bitmap at that moment. A macrotick pulse paces all counting, and a bus-activity level reports frames from any node. The block answers with a one-cycle grant carrying the frame ID to send, and with a one-cycle pulse when the segment's time budget is used up.

Top module: `dyn_seg_arbiter`

## Requirements
- R1: While reset is asserted and after its release, `tx_grant`, `seg_end` and `tx_id` are all zero.
- R2: The slot counter starts at `last_static_id + 1`, so a pending frame with that ID is granted on the first macrotick of the segment.
- R3: A minislot with no bus activity lasts `minislot_len` macroticks (a value of 0 counts as 1), and the slot ID then goes up by exactly one.
- R4: If bus activity is seen while no frame is in progress, that slot is occupied and no grant is given in it. The slot ID goes up by one on the first macrotick after the activity ends, and the next slot begins on the macrotick after that. For a local grant, the grant macrotick itself belongs to the occupied slot.
- R5: Bit i of `pend_req` stands for frame ID i. Pending frames are granted in ascending ID order, and each ID is granted at most once per segment, because its captured bit is cleared when it is granted.
- R6: A grant happens only on a macrotick that opens a minislot, and the bus must be idle at that moment. `tx_grant` goes high for one clock in the cycle after that macrotick.
- R7: A pending slot is granted only if the macroticks left, counting the current one, are at least `max_frame_len`. The first pending slot that fails this test stops all further grants until the next segment start.
- R8: `seg_end` pulses for one clock after the `seg_len`-th macrotick following the segment start. No grant follows until the next start, and frames left unsent can be granted in a later segment.
- R9: The slot counter saturates at parameter `MAX_ID`, and a start value above `MAX_ID` is clamped to it.
- R10: `pend_req` is sampled only on `seg_start`; changes to it during a segment do not alter the grants.
- R11: Nothing advances on clock cycles without `mt_tick`; the grant timing counted in macroticks does not depend on the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_tick | input | 1 | One-cycle pulse per macrotick (action point) |
| seg_start | input | 1 | Pulse opening the dynamic segment; loads configuration and pending bitmap |
| bus_busy | input | 1 | High while a frame from any node occupies the bus |
| last_static_id | input | ID_W | Frame ID of the last static slot |
| minislot_len | input | MS_W | Minislot length in macroticks |
| seg_len | input | MT_W | Dynamic segment length in macroticks |
| max_frame_len | input | MT_W | Macroticks a local frame needs at most |
| pend_req | input | MAX_ID+1 | Bitmap of pending local frame IDs |
| tx_grant | output | 1 | One-cycle pulse: send frame `tx_id` now |
| tx_id | output | ID_W | Frame ID belonging to the grant |
| seg_end | output | 1 | One-cycle pulse when the segment budget runs out |

## Verification
The bench builds the arbiter with a 5-bit ID, `MAX_ID` of 20, an 8-bit macrotick budget and a 4-bit minislot length. With these values a handful of segments reaches the saturation ceiling, a start value clamped onto it, and budget exhaustion. The short segment budget also makes one-macrotick minislots and carried-over frames affordable. A slot-walk model in the bench derives every expected grant and the bus activity that follows it, and remote frames are injected into chosen slots. Tick spacing of one and two clocks is used.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef logic [31:0] dsa_word_t;

  // Slot the dynamic segment opens with, clamped to the ceiling.
  function automatic dsa_word_t first_slot(dsa_word_t last_static, dsa_word_t max_id);
    dsa_word_t cand;
    cand = last_static + 32'd1;
    return (cand > max_id) ? max_id : cand;
  endfunction

  // One step of the slot counter, saturating at the ceiling.
  function automatic dsa_word_t next_slot(dsa_word_t cur, dsa_word_t max_id);
    return (cur >= max_id) ? max_id : cur + 32'd1;
  endfunction

  // True on the last macrotick of an idle minislot; length 0 behaves as 1.
  function automatic logic minislot_over(dsa_word_t cnt, dsa_word_t len);
    return (len <= 32'd1) || (cnt == len - 32'd1);
  endfunction

  // Enough budget left (current macrotick included) for a full frame.
  function automatic logic budget_ok(dsa_word_t remain, dsa_word_t need);
    return remain >= need;
  endfunction

endpackage

// File: rtl/dsa_seg_timer.sv
module dsa_seg_timer #(
  parameter int MT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mt_tick,
  input  logic            seg_start,
  input  logic [MT_W-1:0] seg_len,
  output logic            active_o,
  output logic [MT_W-1:0] remain_o,
  output logic            seg_end_o
);

  logic            active_q;
  logic [MT_W-1:0] remain_q;
  logic            end_q;
  logic            last_tick;

  assign last_tick = mt_tick && active_q && (remain_q == MT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
      end_q    <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (seg_start) begin
        active_q <= (seg_len != '0);
        remain_q <= seg_len;
      end else if (mt_tick && active_q) begin
        remain_q <= remain_q - MT_W'(1);
        if (last_tick) begin
          active_q <= 1'b0;
          end_q    <= 1'b1;
        end
      end
    end
  end

  assign active_o  = active_q;
  assign remain_o  = remain_q;
  assign seg_end_o = end_q;

  a_r8_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q);

  a_r8_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (!active_q && remain_q == '0));

endmodule

// File: rtl/dsa_slot_ctr.sv
module dsa_slot_ctr
  import dsa_pkg::*;
#(
  parameter int ID_W   = 7,
  parameter int MS_W   = 6,
  parameter int MAX_ID = 127
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seg_start,
  input  logic            active,
  input  logic            mt_tick,
  input  logic            bus_busy,
  input  logic            grant_now,
  input  logic [ID_W-1:0] first_id,
  input  logic [MS_W-1:0] minislot_len,
  output logic [ID_W-1:0] slot_o,
  output logic            at_boundary_o,
  output logic            in_frame_o
);

  localparam logic [ID_W-1:0] MAX_SLOT = ID_W'(MAX_ID);

  logic [ID_W-1:0] slot_q;
  logic [MS_W-1:0] ms_q;
  logic            in_frame_q;
  logic [ID_W-1:0] slot_nxt;
  logic            ms_last;
  logic            frame_adv;   // occupied slot released by a quiet bus
  logic            idle_adv;    // idle minislot expired
  logic            frame_seen;  // bus activity opens an occupied slot

  assign slot_nxt   = ID_W'(next_slot(32'(slot_q), 32'(MAX_ID)));
  assign ms_last    = minislot_over(32'(ms_q), 32'(minislot_len));
  assign frame_adv  = active && mt_tick && in_frame_q && !bus_busy;
  assign frame_seen = active && !in_frame_q && bus_busy;
  assign idle_adv   = active && mt_tick && !in_frame_q && !bus_busy && !grant_now && ms_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q     <= '0;
      ms_q       <= '0;
      in_frame_q <= 1'b0;
    end else if (seg_start) begin
      slot_q     <= first_id;
      ms_q       <= '0;
      in_frame_q <= 1'b0;
    end else if (frame_adv || idle_adv) begin
      in_frame_q <= 1'b0;
      slot_q     <= slot_nxt;
      ms_q       <= '0;
    end else if (frame_seen || (active && mt_tick && grant_now)) begin
      in_frame_q <= 1'b1;
      ms_q       <= '0;
    end else if (active && mt_tick && !in_frame_q) begin
      ms_q <= ms_q + MS_W'(1);
    end
  end

  assign slot_o        = slot_q;
  assign at_boundary_o = !in_frame_q && (ms_q == '0);
  assign in_frame_o    = in_frame_q;

  a_r9_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= MAX_SLOT);

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_start) |=> (slot_q == $past(slot_q) || slot_q == $past(slot_q) + ID_W'(1)));

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_frame_q && bus_busy && !seg_start) |=> (slot_q == $past(slot_q) && in_frame_q));

  a_r11_no_tick_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!mt_tick && !seg_start) |=> (slot_q == $past(slot_q)));

endmodule

// File: rtl/dsa_pending.sv
module dsa_pending #(
  parameter int ID_W   = 7,
  parameter int MAX_ID = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_start,
  input  logic [MAX_ID:0]   pend_req,
  input  logic              grant_now,
  input  logic [ID_W-1:0]   slot_id,
  output logic              hit_o,
  output logic [MAX_ID:0]   pend_o
);

  logic [MAX_ID:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (seg_start) begin
      pend_q <= pend_req;
    end else if (grant_now) begin
      pend_q[slot_id] <= 1'b0;
    end
  end

  assign hit_o  = pend_q[slot_id];
  assign pend_o = pend_q;

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_start && !grant_now) |=> (pend_q == $past(pend_q)));

endmodule

// File: rtl/dyn_seg_arbiter.sv
module dyn_seg_arbiter
  import dsa_pkg::*;
#(
  parameter int ID_W   = 7,
  parameter int MAX_ID = 127,
  parameter int MT_W   = 12,
  parameter int MS_W   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mt_tick,
  input  logic            seg_start,
  input  logic            bus_busy,
  input  logic [ID_W-1:0] last_static_id,
  input  logic [MS_W-1:0] minislot_len,
  input  logic [MT_W-1:0] seg_len,
  input  logic [MT_W-1:0] max_frame_len,
  input  logic [MAX_ID:0] pend_req,
  output logic            tx_grant,
  output logic [ID_W-1:0] tx_id,
  output logic            seg_end
);

  logic            active;
  logic [MT_W-1:0] remain;
  logic [ID_W-1:0] slot_id;
  logic [ID_W-1:0] first_id;
  logic            at_boundary;
  logic            in_frame;
  logic            pend_hit;
  logic [MAX_ID:0] pend_vec;
  logic            offer;       // pending local frame meets an open, idle minislot
  logic            fits;
  logic            grant_now;
  logic            stop_now;
  logic            stop_q;
  logic            grant_q;
  logic [ID_W-1:0] id_q;

  assign first_id = ID_W'(first_slot(32'(last_static_id), 32'(MAX_ID)));

  dsa_seg_timer #(.MT_W(MT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mt_tick   (mt_tick),
    .seg_start (seg_start),
    .seg_len   (seg_len),
    .active_o  (active),
    .remain_o  (remain),
    .seg_end_o (seg_end)
  );

  dsa_slot_ctr #(.ID_W(ID_W), .MS_W(MS_W), .MAX_ID(MAX_ID)) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .seg_start     (seg_start),
    .active        (active),
    .mt_tick       (mt_tick),
    .bus_busy      (bus_busy),
    .grant_now     (grant_now),
    .first_id      (first_id),
    .minislot_len  (minislot_len),
    .slot_o        (slot_id),
    .at_boundary_o (at_boundary),
    .in_frame_o    (in_frame)
  );

  dsa_pending #(.ID_W(ID_W), .MAX_ID(MAX_ID)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_start (seg_start),
    .pend_req  (pend_req),
    .grant_now (grant_now),
    .slot_id   (slot_id),
    .hit_o     (pend_hit),
    .pend_o    (pend_vec)
  );

  assign offer     = active && mt_tick && !seg_start && at_boundary && !bus_busy
                     && pend_hit && !stop_q;
  assign fits      = budget_ok(32'(remain), 32'(max_frame_len));
  assign grant_now = offer && fits;
  assign stop_now  = offer && !fits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      grant_q <= 1'b0;
      id_q    <= '0;
    end else begin
      grant_q <= grant_now;
      if (grant_now) id_q <= slot_id;
      if (seg_start)     stop_q <= 1'b0;
      else if (stop_now) stop_q <= 1'b1;
    end
  end

  assign tx_grant = grant_q;
  assign tx_id    = id_q;

  a_r6_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> $past(mt_tick));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> !pend_vec[tx_id]);

  a_r7_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !seg_start) |=> !tx_grant);

  a_r8_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !tx_grant);

  a_r4_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !seg_start) |=> !tx_grant);

endmodule

// File: tb/dyn_seg_arbiter_bench.sv
module dyn_seg_arbiter_bench;

  localparam int ID_W   = 5;
  localparam int MAX_ID = 20;
  localparam int MT_W   = 8;
  localparam int MS_W   = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mt_tick;
  logic            seg_start;
  logic            bus_busy;
  logic [ID_W-1:0] last_static_id;
  logic [MS_W-1:0] minislot_len;
  logic [MT_W-1:0] seg_len;
  logic [MT_W-1:0] max_frame_len;
  logic [MAX_ID:0] pend_req;
  logic            tx_grant;
  logic [ID_W-1:0] tx_id;
  logic            seg_end;

  always #5 clk = ~clk;

  dyn_seg_arbiter #(.ID_W(ID_W), .MAX_ID(MAX_ID), .MT_W(MT_W), .MS_W(MS_W)) u_dyn_seg_arbiter (
    .clk(clk), .rst_n(rst_n), .mt_tick(mt_tick), .seg_start(seg_start), .bus_busy(bus_busy),
    .last_static_id(last_static_id), .minislot_len(minislot_len), .seg_len(seg_len),
    .max_frame_len(max_frame_len), .pend_req(pend_req),
    .tx_grant(tx_grant), .tx_id(tx_id), .seg_end(seg_end)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cur_tick = 0;
  bit done     = 0;

  // Scoreboard: kind 0 = grant, kind 1 = segment end
  int    q_kind[$];
  int    q_id[$];
  int    q_tick[$];
  string q_req[$];

  int busy_at[0:255];
  int rem_len[0:31];

  task automatic note(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_ev(int kind, int id, int t, string req);
    q_kind.push_back(kind);
    q_id.push_back(id);
    q_tick.push_back(t);
    q_req.push_back(req);
  endtask

  task automatic check_ev(int kind, int id);
    int ek, ei, et;
    string er;
    n_checks++;
    if (q_kind.size() == 0) begin
      n_fail++;
      $display("FAIL R8 unexpected event: actual kind=%0d id=%0d tick=%0d expected none",
               kind, id, cur_tick);
    end else begin
      ek = q_kind.pop_front();
      ei = q_id.pop_front();
      et = q_tick.pop_front();
      er = q_req.pop_front();
      if (ek != kind || ei != id || et != cur_tick) begin
        n_fail++;
        $display("FAIL %s event: actual kind=%0d id=%0d tick=%0d expected kind=%0d id=%0d tick=%0d",
                 er, kind, id, cur_tick, ek, ei, et);
      end
    end
  endtask

  // Monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1 && !done) begin
      if (tx_grant) check_ev(0, int'(tx_id));
      if (seg_end)  check_ev(1, 0);
    end
  end

  // Slot-walk model: each slot costs L idle macroticks, a remote frame
  // costs its length plus one, a local frame its length plus two.
  task automatic plan_seg(int ls, int L, int S, int F, logic [MAX_ID:0] pend, int B, string req);
    int s, t, step;
    bit stop;
    logic [MAX_ID:0] pm;
    for (int i = 0; i < 256; i++) busy_at[i] = 0;
    pm   = pend;
    s    = (ls + 1 > MAX_ID) ? MAX_ID : ls + 1;
    t    = 0;
    stop = 0;
    step = (L < 1) ? 1 : L;
    while (t < S) begin
      if (rem_len[s] > 0) begin
        for (int k = 0; k < rem_len[s]; k++) busy_at[t + k] = 1;
        t = t + rem_len[s] + 1;
      end else if (pm[s] && !stop) begin
        if (S - t >= F) begin
          push_ev(0, s, t, req);
          for (int k = 1; k <= B; k++) busy_at[t + k] = 1;
          pm[s] = 1'b0;
          t = t + B + 2;
        end else begin
          stop = 1;
          t = t + step;
        end
      end else begin
        t = t + step;
      end
      s = (s >= MAX_ID) ? MAX_ID : s + 1;
    end
    push_ev(1, 0, S - 1, "R8");
  endtask

  task automatic run_seg(int p, int ls, int L, int S, int F, logic [MAX_ID:0] pend,
                         logic [MAX_ID:0] alt, int change_at, string req);
    @(negedge clk);
    last_static_id = ID_W'(ls);
    minislot_len   = MS_W'(L);
    seg_len        = MT_W'(S);
    max_frame_len  = MT_W'(F);
    pend_req       = pend;
    seg_start      = 1'b1;
    @(negedge clk);
    seg_start = 1'b0;
    for (int t = 0; t < S + 3; t++) begin
      if (t == change_at) pend_req = alt;
      mt_tick  = 1'b1;
      bus_busy = (busy_at[t] != 0);
      cur_tick = t;
      @(negedge clk);
      mt_tick = 1'b0;
      for (int g = 1; g < p; g++) @(negedge clk);
    end
    bus_busy = 1'b0;
    mt_tick  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    note(q_kind.size() == 0, req, "expected events left over", q_kind.size(), 0);
    q_kind.delete(); q_id.delete(); q_tick.delete(); q_req.delete();
  endtask

  task automatic scen(int p, int ls, int L, int S, int F, logic [MAX_ID:0] pend, int B,
                      logic [MAX_ID:0] alt, int change_at, string req);
    plan_seg(ls, L, S, F, pend, B, req);
    run_seg(p, ls, L, S, F, pend, alt, change_at, req);
  endtask

  function automatic logic [MAX_ID:0] bits3(int a, int b, int c);
    logic [MAX_ID:0] v;
    v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; mt_tick = 1'b0; seg_start = 1'b0; bus_busy = 1'b0;
    last_static_id = '0; minislot_len = '0; seg_len = '0; max_frame_len = '0; pend_req = '0;
    for (int i = 0; i < 32; i++) rem_len[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    note(tx_grant == 1'b0, "R1", "tx_grant in reset", int'(tx_grant), 0);
    note(seg_end == 1'b0,  "R1", "seg_end in reset",  int'(seg_end), 0);
    note(tx_id == '0,      "R1", "tx_id in reset",    int'(tx_id), 0);
    rst_n = 1'b1;
    @(negedge clk);
    note(tx_grant == 1'b0 && seg_end == 1'b0, "R1", "outputs after release",
         int'(tx_grant) + int'(seg_end), 0);

    // R2: first dynamic slot follows the last static one
    scen(1, 3, 2, 40, 6, bits3(4, 7, 9), 4, '0, -1, "R2");
    // R3: idle minislots of four macroticks before a late frame
    scen(1, 0, 4, 30, 4, bits3(4, -1, -1), 2, '0, -1, "R3");
    // R4: remote frames occupy slots 1 and 3
    rem_len[1] = 3; rem_len[3] = 2;
    scen(1, 0, 3, 50, 5, bits3(2, 5, 6), 4, '0, -1, "R4");
    rem_len[1] = 0; rem_len[3] = 0;
    // R5: ceiling slot repeats but its frame goes out once
    scen(1, 20, 2, 24, 4, bits3(20, 3, -1), 2, '0, -1, "R5");
    // R6: back-to-back pending IDs, next grant right at the reopened minislot
    scen(1, 1, 5, 30, 4, bits3(2, 3, -1), 3, '0, -1, "R6");
    // R7: budget runs out before slot 17
    scen(1, 10, 2, 20, 8, bits3(12, 17, 19), 3, '0, -1, "R7");
    // R8: leftovers served in the following, longer segment
    scen(1, 10, 2, 60, 8, bits3(12, 17, 19), 3, '0, -1, "R8");
    // R9: counter saturates at MAX_ID with one-macrotick minislots
    scen(1, 17, 1, 30, 4, bits3(18, 20, -1), 2, '0, -1, "R9");
    // R10: pending input changed mid-segment has no effect
    scen(1, 5, 3, 45, 4, bits3(6, 7, 8), 2, '1, 5, "R10");
    // R11: macroticks spaced two clocks apart
    scen(2, 5, 3, 45, 4, bits3(6, 7, 8), 2, '0, -1, "R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule